// File: doc/BRIEF.md
# Region Write-Guarded Byte RAM

This block is a single-port, byte-wide synchronous RAM in which writes can be fenced off region by region. The address space is cut into equal slices, and a mask register holds one enable bit per slice. A RAM write lands only if the enable bit of the slice it targets is set. The mask register itself can only change while a privilege input is high. A processor drives this input from its interrupt flag, so only interrupt or supervisor code can change which slices are writable.

Two build-time choices shape the block. The first selects the size: 1K bytes split into 16 slices of 64 bytes, or 4K bytes split into 32 slices of 128 bytes. The second turns the guard on or off. With the guard off, which is the default, the block is an ordinary RAM. A separate select strobe steers a bus cycle to the mask register instead of the RAM. In that case the low address bits pick one mask byte, both to read it and to write it.

Top module: `region_guard_ram`

## Requirements
- R1: A RAM read returns, on `rd_data`, the byte at `addr` as sampled on a clock edge. The byte is valid from that edge until the next one, so the read latency is one clock.
- R2: With the guard enabled, a RAM write (`wr_en` high, `mask_sel` low) to a slice whose mask bit is 0 is dropped. That byte keeps its old content.
- R3: A RAM write to a slice whose mask bit is 1 stores `wr_data` at `addr`.
- R4: While `rst_n` is low at a clock edge, the whole mask register clears to 0 and `rd_data` reads 0. After reset, every slice of a guarded instance is therefore closed.
- R5: A mask write attempted while `priv` is low leaves the mask register unchanged.
- R6: The mask register is written only when `mask_sel` and `wr_en` are high in the same cycle. A cycle with `mask_sel` high never writes the RAM. A cycle with `mask_sel` high returns mask byte k one clock later, where k is the low address bits (`addr[0]` in 1K, `addr[1:0]` in 4K). Bit j of byte k is the enable of slice 8k+j.
- R7: The slice index is `addr[9:6]` in the 1K configuration and `addr[11:7]` in the 4K configuration.
- R8: With the guard disabled, every RAM write stores its data whatever the mask holds.
- R9: A read of the address being written in the same cycle returns the content from before that write. The same holds for a mask byte read in the cycle it is written.
- R10: Reads are never blocked: bytes in closed slices read back normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 10 (1K) / 12 (4K) | Byte address, or mask byte index when `mask_sel` is high |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| mask_sel | input | 1 | Steers the cycle to the mask register |
| priv | input | 1 | Privilege flag; mask writes accepted only when high |
| rd_data | output | 8 | Registered read data (RAM byte or mask byte) |

## Verification
Two functions can fall in the same cycle, and each pairing is provoked on purpose.

The first pairing is a read of a location together with a write to it. The bench issues back-to-back writes to the same address and the same mask byte. A reference model then checks that each cycle returns the content from before that cycle's write.

The second pairing is a guard decision together with a mask change. The bench drives the privilege flag and the mask strobe from a pseudo-random sequence, mixed with RAM writes that straddle slice boundaries. Three instances (1K guarded, 4K guarded, 1K open) see the same stimulus. Every clock, each instance is compared with a behavioural model of its own configuration.

// File: rtl/rgr_pkg.sv
// Package: shared sizing helpers for the region write-guarded RAM.
// Assumes the two supported sizes only: 1K (16 slices) and 4K (32 slices).
package rgr_pkg;

    typedef logic [7:0] byte_t;

    // Address width for the selected size.
    function automatic int addr_bits(input bit big);
        return big ? 12 : 10;
    endfunction

    // Lowest address bit of the slice index.
    function automatic int slice_lsb(input bit big);
        return big ? 7 : 6;
    endfunction

    // Number of guarded slices.
    function automatic int slice_count(input bit big);
        return big ? 32 : 16;
    endfunction

endpackage

// File: rtl/rgr_byte_store.sv
// Module: byte-wide storage array with one synchronous write port and a
// registered read port sharing the same address.
// Assumes the caller has already decided whether a write may land.
// Read-before-write: a read of the address being written returns old data.
module rgr_byte_store #(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  rgr_pkg::byte_t      wd_i,
    output rgr_pkg::byte_t      rd_o
);

    rgr_pkg::byte_t cells [DEPTH];
    rgr_pkg::byte_t rd_q;

    // Store a byte when the write is permitted.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[addr_i] <= wd_i;
        end
    end

    // Register the addressed byte; cleared while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= cells[addr_i];
        end
    end

    assign rd_o = rd_q;

endmodule

// File: rtl/rgr_region_decode.sv
// Module: maps a byte address to its slice index and reports whether that
// slice currently accepts writes.
// Assumes the slice index occupies the top address bits from SLICE_LSB up.
// With GUARD low every slice is reported open.
module rgr_region_decode #(
    parameter int ADDR_W    = 10,
    parameter int SLICE_LSB = 6,
    parameter int SLICES    = 16,
    parameter bit GUARD     = 1'b0,
    localparam int SIDX_W   = $clog2(SLICES)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SLICES-1:0] mask_i,
    output logic [SIDX_W-1:0] slice_o,
    output logic              open_o
);

    logic mask_bit;

    // Pick the slice field and look up its enable bit.
    always_comb begin
        slice_o  = addr_i[SLICE_LSB +: SIDX_W];
        mask_bit = mask_i[slice_o];
        open_o   = GUARD ? mask_bit : 1'b1;
    end

endmodule

// File: rtl/rgr_mask_bank.sv
// Module: the slice-enable register, organised as bytes of eight slices.
// Assumes the caller decodes the byte index from the low address bits.
// A byte changes only when select, write strobe and privilege are all high.
// Reset clears every enable.
module rgr_mask_bank #(
    parameter int SLICES  = 16,
    localparam int BYTES  = SLICES / 8,
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               we_i,
    input  logic               priv_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  rgr_pkg::byte_t     wd_i,
    output logic [SLICES-1:0]  mask_o,
    output rgr_pkg::byte_t     rd_o
);

    logic           upd;
    rgr_pkg::byte_t rd_q;

    assign upd = sel_i & we_i & priv_i;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        // Hold one byte of slice enables; load it on a privileged mask write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o[k*8 +: 8] <= '0;
            end else if (upd && (idx_i == IDX_W'(k))) begin
                mask_o[k*8 +: 8] <= wd_i;
            end
        end
    end

    // Register the selected mask byte for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= mask_o[idx_i*8 +: 8];
        end
    end

    assign rd_o = rd_q;

    // R5
    mask_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_i |=> $stable(mask_o));

    // R6
    mask_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && we_i) |=> $stable(mask_o));

    // R4
    mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_o == '0));

endmodule

// File: rtl/region_guard_ram.sv
// Module: byte RAM whose writes are fenced per slice by a privileged mask.
// Assumes a single bus master; mask_sel steers a cycle to the mask register.
// BIG_CFG picks 4K/32 slices (1) or 1K/16 slices (0); GUARD enables fencing.
module region_guard_ram #(
    parameter bit BIG_CFG = 1'b0,
    parameter bit GUARD   = 1'b0,
    localparam int ADDR_W = rgr_pkg::addr_bits(BIG_CFG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en,
    input  logic              mask_sel,
    input  logic              priv,
    output logic [7:0]        rd_data
);

    localparam int SLICES    = rgr_pkg::slice_count(BIG_CFG);
    localparam int SLICE_LSB = rgr_pkg::slice_lsb(BIG_CFG);
    localparam int SIDX_W    = $clog2(SLICES);
    localparam int IDX_W     = $clog2(SLICES / 8);

    logic [SLICES-1:0] mask_vec;
    logic [SIDX_W-1:0] slice_idx;
    logic              slice_open;
    logic              mem_we;
    logic              sel_q;
    rgr_pkg::byte_t    mem_rd;
    rgr_pkg::byte_t    mask_rd;

    rgr_region_decode #(
        .ADDR_W    (ADDR_W),
        .SLICE_LSB (SLICE_LSB),
        .SLICES    (SLICES),
        .GUARD     (GUARD)
    ) u_decode (
        .addr_i  (addr),
        .mask_i  (mask_vec),
        .slice_o (slice_idx),
        .open_o  (slice_open)
    );

    rgr_mask_bank #(
        .SLICES (SLICES)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (mask_sel),
        .we_i   (wr_en),
        .priv_i (priv),
        .idx_i  (addr[IDX_W-1:0]),
        .wd_i   (wr_data),
        .mask_o (mask_vec),
        .rd_o   (mask_rd)
    );

    // A RAM write needs the strobe, a RAM-directed cycle and an open slice.
    assign mem_we = rst_n & wr_en & ~mask_sel & slice_open;

    rgr_byte_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mem_we),
        .addr_i (addr),
        .wd_i   (wr_data),
        .rd_o   (mem_rd)
    );

    // Remember which source the registered read data comes from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= mask_sel;
        end
    end

    assign rd_data = sel_q ? mask_rd : mem_rd;

    // R2
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!GUARD || mask_vec[slice_idx]));

endmodule

// File: tb/region_guard_ram_bench.sv
`timescale 1ns/100ps
// Bench: three instances (1K guarded, 4K guarded, 1K open) on shared stimulus,
// each compared every clock against a behavioural model of its configuration.
module region_guard_ram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] a_bus = '0;
    logic [7:0]  wd = '0;
    logic        w_en = 1'b0;
    logic        m_sel = 1'b0;
    logic        prv = 1'b0;
    logic [7:0]  rd_g1k, rd_g4k, rd_o1k;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R4";

    always #2.5 clk = ~clk;

    region_guard_ram #(.BIG_CFG(1'b0), .GUARD(1'b1)) u_region_guard_ram (
        .clk(clk), .rst_n(rst_n), .addr(a_bus[9:0]), .wr_data(wd),
        .wr_en(w_en), .mask_sel(m_sel), .priv(prv), .rd_data(rd_g1k));

    region_guard_ram #(.BIG_CFG(1'b1), .GUARD(1'b1)) u_region_guard_ram_4k (
        .clk(clk), .rst_n(rst_n), .addr(a_bus), .wr_data(wd),
        .wr_en(w_en), .mask_sel(m_sel), .priv(prv), .rd_data(rd_g4k));

    region_guard_ram u_region_guard_ram_open (
        .clk(clk), .rst_n(rst_n), .addr(a_bus[9:0]), .wr_data(wd),
        .wr_en(w_en), .mask_sel(m_sel), .priv(prv), .rd_data(rd_o1k));

    // Behavioural models, one per instance.
    bit          big  [3] = '{1'b0, 1'b1, 1'b0};
    bit          prot [3] = '{1'b1, 1'b1, 1'b0};
    logic [7:0]  mmem [3][4096];
    bit          mv   [3][4096];
    logic [31:0] mmask[3];
    logic [7:0]  expd [3];
    bit          expv [3] = '{1'b0, 1'b0, 1'b0};
    string       etag [3];

    always @(posedge clk) begin
        for (int d = 0; d < 3; d++) begin
            int a, rg, bi;
            a = big[d] ? int'(a_bus) : int'(a_bus[9:0]);
            if (!rst_n) begin
                mmask[d] = '0;
                expd[d]  = '0;
                expv[d]  = 1'b1;
            end else if (m_sel) begin
                bi = big[d] ? (a % 4) : (a % 2);
                expd[d] = mmask[d][bi*8 +: 8];
                expv[d] = 1'b1;
                if (w_en && prv) mmask[d][bi*8 +: 8] = wd;
            end else begin
                expd[d] = mmem[d][a];
                expv[d] = mv[d][a];
                rg = big[d] ? (a / 128) : (a / 64);
                if (w_en && (!prot[d] || mmask[d][rg])) begin
                    mmem[d][a] = wd;
                    mv[d][a]   = 1'b1;
                end
            end
            etag[d] = cur_req;
        end
    end

    task automatic check(input string req, input int dut, input logic [7:0] got,
                         input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s dut%0d got=%h expected=%h", req, dut, got, exp);
        end
    endtask

    // Compare every instance with its model away from the active edge.
    always @(negedge clk) begin
        if (expv[0]) check(etag[0], 0, rd_g1k, expd[0]);
        if (expv[1]) check(etag[1], 1, rd_g4k, expd[1]);
        if (expv[2]) check(etag[2], 2, rd_o1k, expd[2]);
    end

    task automatic cyc(input logic s, input logic w, input logic p,
                       input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        m_sel = s; w_en = w; prv = p; a_bus = a; wd = d;
    endtask

    task automatic ram_wr(input logic [11:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic ram_rd(input logic [11:0] a);
        cyc(1'b0, 1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before the sequence ended");
            summary();
            $finish;
        end
    end

    logic [31:0] lf = 32'h1ACE_B00C;

    initial begin
        // R4: reset state, outputs and mask read back zero
        cur_req = "R4";
        repeat (4) @(negedge clk);
        check("R4", 0, rd_g1k, 8'h00);
        check("R4", 1, rd_g4k, 8'h00);
        check("R4", 2, rd_o1k, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 1'b0, 12'(k), 8'h00);
        // R2: closed after reset, writes drop (only the open instance stores)
        cur_req = "R2";
        ram_wr(12'h010, 8'h5A);
        ram_rd(12'h010);
        // R5: unprivileged mask write is dropped
        cur_req = "R5";
        cyc(1'b1, 1'b1, 1'b0, 12'h000, 8'hFF);
        cyc(1'b1, 1'b0, 1'b0, 12'h000, 8'h00);
        // R6: select without strobe does not write; select with strobe does
        cur_req = "R6";
        cyc(1'b1, 1'b0, 1'b1, 12'h001, 8'hFF);
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, 12'(k), 8'hFF);
        // R9: mask byte read while written returns the prior value
        cur_req = "R9";
        cyc(1'b1, 1'b1, 1'b1, 12'h001, 8'hFE);
        cyc(1'b1, 1'b1, 1'b1, 12'h001, 8'hFF);
        cyc(1'b1, 1'b0, 1'b0, 12'h001, 8'h00);
        // R3: with all slices open, writes land; R1 read-back next clock
        cur_req = "R3";
        for (int i = 0; i < 64; i++) ram_wr(12'((i * 67) % 4096), 8'(i * 7 + 3));
        cur_req = "R1";
        for (int i = 0; i < 64; i++) ram_rd(12'((i * 67) % 4096));
        // R9: back-to-back writes to one address
        cur_req = "R9";
        ram_wr(12'h123, 8'h11);
        ram_wr(12'h123, 8'h22);
        ram_rd(12'h123);
        // R2 / R10: close mask byte 0 then overwrite and read
        cur_req = "R2";
        cyc(1'b1, 1'b1, 1'b1, 12'h000, 8'h00);
        for (int i = 0; i < 64; i++) ram_wr(12'((i * 67) % 4096), 8'hC3);
        cur_req = "R10";
        for (int i = 0; i < 64; i++) ram_rd(12'((i * 67) % 4096));
        // R7: slice boundaries, slice 1 closed and a high slice closed
        cur_req = "R7";
        cyc(1'b1, 1'b1, 1'b1, 12'h000, 8'hFD);
        cyc(1'b1, 1'b1, 1'b1, 12'h001, 8'h7F);
        foreach (lf[i]) begin end
        for (int j = 0; j < 2; j++) begin
            ram_wr(12'd63,   8'(8'h40 + j));  ram_wr(12'd64,   8'(8'h41 + j));
            ram_wr(12'd127,  8'(8'h42 + j));  ram_wr(12'd128,  8'(8'h43 + j));
            ram_wr(12'd1000, 8'(8'h44 + j));  ram_wr(12'd1920, 8'(8'h45 + j));
            ram_wr(12'd3970, 8'(8'h46 + j));
        end
        ram_rd(12'd63); ram_rd(12'd64); ram_rd(12'd127); ram_rd(12'd128);
        ram_rd(12'd1000); ram_rd(12'd1920); ram_rd(12'd3970);
        // R5 again: mask unchanged after unprivileged attempt
        cur_req = "R5";
        cyc(1'b1, 1'b1, 1'b0, 12'h000, 8'hFF);
        cyc(1'b1, 1'b0, 1'b0, 12'h000, 8'h00);
        ram_wr(12'd64, 8'hEE); ram_rd(12'd64);
        // R8 and mixed traffic: pseudo-random ops with privilege toggling
        cur_req = "R8";
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cyc(lf[2:0] == 3'd0, lf[3], lf[5:4] == 2'd0, lf[19:8] & 12'hCCF, lf[27:20]);
        end
        cyc(1'b0, 1'b0, 1'b0, 12'h000, 8'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule